// File: doc/BRIEF.md
# Three-Lane Interleaved Serializer

This block turns one wide parallel word per loading slot into a single serial bit stream. A word of 3·N bits is taken in on the rising edge of the loading clock. The word is spread across three N-bit shift lanes. Bit 3N−1 goes to lane 0, bit 3N−2 goes to lane 1 and bit 3N−3 goes to lane 2, and the pattern repeats downward. Each lane moves only once every three bit clocks, on its own phase of a rotating three-phase ring. A phase-driven 3:1 selector picks each lane while the phase just before that lane's own phase is active. The three interleaved lanes together give one bit per bit clock, most significant bit first, and words can follow each other with no gap.

The model is fully synchronous on the bit clock. A slot counter of 3N cycles produces the loading clock, which the block exports as `load_clk`. That clock is high for the first half of the slot and low for the second half. A one-hot ring stands in for the three one-third-rate phase clocks. A load sequencer hands the captured word to the lanes after the loading clock falls. It arms on a captured word (S_ARMED) and waits for the falling edge (S_HOLD). It then grants lane 0, lane 1 and lane 2 on successive phases (S_LANE0, S_LANE1, S_LANE2). After that it returns to S_IDLE, or goes straight back to S_ARMED if the next word is taken in that same cycle. The path from load to first bit always has the same number of cycles. A `first_bit` pulse marks the top bit of every loaded word. A half-rate mode sends each of the upper 3N/2 input bits twice, which halves the useful bit rate.

Top module: `ser3_interleaver`

## Requirements
- R1: `load_clk` is high for the first 3N/2 bit cycles of each 3N-cycle slot and low for the rest. `par_data`, `load_req` and `half_rate` are sampled on the clock edge where `load_clk` rises. A word is taken only when `load_req` is 1 at that edge.
- R2: A loaded word W leaves on `sout` one bit per bit clock, in the order W[3N−1], W[3N−2], …, W[0]. The next loaded word follows with no idle cycle.
- R3: After reset is released, the first cycle is slot position 0 with phase 0 active and `load_clk` high. The phases then rotate 0,1,2 in step with the slot.
- R4: Lane k holds bits 3N−1−k−3j for j = 0..N−1. Lane k loads only on a cycle where phase k is active. Within one word, lane 0 loads first, then lane 1, then lane 2, on three consecutive cycles.
- R5: The top bit of a word taken on edge E is on `sout` during the cycle that begins 3N/2+6 clock edges after E. This delay is the same for every word and after every reset.
- R6: `first_bit` is 1 for exactly the one cycle in which the top bit of a newly loaded word is on `sout`, and 0 otherwise.
- R7: In a slot where `load_req` is 0, no word is taken. Once the word in flight has been sent, `sout` is 0, and `first_bit` stays 0 for that slot.
- R8: With `half_rate` = 1 at the loading edge, the word sent is par_data[3N−1], par_data[3N−1], par_data[3N−2], par_data[3N−2], … down to par_data[3N/2] twice. The lower 3N/2 input bits have no effect.
- R9: While `rst` is 1 (synchronous, active high), the lanes, the sequencer and the ring are cleared, and `sout` and `first_bit` are 0. Both stay 0 after release until the first loaded word's top bit is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | 3*N | Parallel word, sampled at the rising edge of the loading clock |
| load_req | input | 1 | Take a word in this slot |
| half_rate | input | 1 | Send each upper-half bit twice |
| load_clk | output | 1 | Loading clock, high for the first half of each slot |
| sout | output | 1 | Serial data, MSB first |
| first_bit | output | 1 | Marks the cycle holding a loaded word's top bit |

## Verification
The bench builds the block with N = 4, so each word is 12 bits and a slot is 12 bit clocks. At that size every one of the 4096 word values is sent back to back, which covers every bit pattern on each lane and the tight case where lane 2 loads on the same edge that the next word is taken. Sixty-four half-rate words cover every upper-half pattern, and their inverted lower halves show that those bits are ignored. Alternating empty slots are followed by a second reset and a rerun, which checks the idle-low behaviour and that the load-to-first-bit delay is the same after a restart.

// File: rtl/ser3_pkg.sv
package ser3_pkg;

    // Lane-load sequencer states
    typedef enum logic [2:0] {
        S_IDLE,   // no word waiting
        S_ARMED,  // word captured, loading clock still high
        S_HOLD,   // loading clock low, waiting for phase 2
        S_LANE0,  // lane 0 takes its bits (phase 0)
        S_LANE1,  // lane 1 takes its bits (phase 1)
        S_LANE2   // lane 2 takes its bits (phase 2)
    } ld_state_t;

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/ser3_phase_gen.sv
module ser3_phase_gen #(
    parameter int SLOT = 30
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] ring,
    output logic       slot_last,
    output logic       fall_pre,
    output logic       load_clk
);
    localparam int CW    = $clog2(SLOT);
    localparam int HALFS = SLOT / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            ring <= 3'b001;
        end else begin
            cnt  <= (cnt == CW'(SLOT - 1)) ? '0 : cnt + CW'(1);
            ring <= {ring[1:0], ring[2]};
        end
    end

    assign slot_last = (cnt == CW'(SLOT - 1));
    assign fall_pre  = (cnt == CW'(HALFS - 1));
    assign load_clk  = (cnt < CW'(HALFS));

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(ring) == 1); // R3
    AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
        slot_last |-> ring[2]); // R3

endmodule

// File: rtl/ser3_lane.sv
module ser3_lane #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic [N-1:0] par_in,
    output logic         msb
);
    logic [N-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load_en) begin
            sr <= par_in;
        end else if (shift_en) begin
            sr <= {sr[N-2:0], 1'b0};
        end
    end

    assign msb = sr[N-1];

    AST_LOAD_ON_OWN_PHASE: assert property (@(posedge clk) disable iff (rst)
        load_en |-> shift_en); // R4

endmodule

// File: rtl/ser3_load_fsm.sv
module ser3_load_fsm
    import ser3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_req,
    input  logic       slot_last,
    input  logic       fall_pre,
    input  logic       ph2,
    output logic [2:0] lane_ld
);
    ld_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (slot_last && load_req) nxt = S_ARMED;
            S_ARMED: if (fall_pre) nxt = S_HOLD;
            S_HOLD:  if (ph2) nxt = S_LANE0;
            S_LANE0: nxt = S_LANE1;
            S_LANE1: nxt = S_LANE2;
            S_LANE2: nxt = (slot_last && load_req) ? S_ARMED : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        lane_ld[0] = (state == S_LANE0);
        lane_ld[1] = (state == S_LANE1);
        lane_ld[2] = (state == S_LANE2);
    end

    AST_ARM_ONLY_AT_SLOT_END: assert property (@(posedge clk) disable iff (rst)
        (state != S_ARMED && nxt == S_ARMED) |-> (slot_last && load_req)); // R1

endmodule

// File: rtl/ser3_interleaver.sv
module ser3_interleaver
    import ser3_pkg::*;
#(
    parameter int N = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3*N-1:0]   par_data,
    input  logic             load_req,
    input  logic             half_rate,
    output logic             load_clk,
    output logic             sout,
    output logic             first_bit
);
    localparam int W     = NUM_LANES * N;
    localparam int HALFW = W / 2;

    logic [2:0]   ring;
    logic         slot_last;
    logic         fall_pre;
    logic [2:0]   lane_ld;
    logic [2:0]   lane_msb;
    logic [W-1:0] dup;
    logic [W-1:0] hold;
    logic         pick;
    logic         fresh0;

    ser3_phase_gen #(.SLOT(W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .ring      (ring),
        .slot_last (slot_last),
        .fall_pre  (fall_pre),
        .load_clk  (load_clk)
    );

    ser3_load_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .load_req  (load_req),
        .slot_last (slot_last),
        .fall_pre  (fall_pre),
        .ph2       (ring[2]),
        .lane_ld   (lane_ld)
    );

    // half-rate word: each upper-half bit repeated
    for (genvar i = 0; i < HALFW; i++) begin : g_dup
        assign dup[W-1-2*i] = par_data[W-1-i];
        assign dup[W-2-2*i] = par_data[W-1-i];
    end

    always_ff @(posedge clk) begin
        if (rst)                         hold <= '0;
        else if (slot_last && load_req)  hold <= half_rate ? dup : par_data;
    end

    // deal bits round-robin from the top into three lanes
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [N-1:0] lane_in;
        for (genvar j = 0; j < N; j++) begin : g_bit
            assign lane_in[N-1-j] = hold[W-1-k-NUM_LANES*j];
        end
        ser3_lane #(.N(N)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .load_en  (lane_ld[k]),
            .shift_en (ring[k]),
            .par_in   (lane_in),
            .msb      (lane_msb[k])
        );
    end

    // lane k is selected during the phase preceding its own
    always_comb begin
        pick = (ring[2] & lane_msb[0]) |
               (ring[0] & lane_msb[1]) |
               (ring[1] & lane_msb[2]);
    end

    always_ff @(posedge clk) begin
        if (rst)             fresh0 <= 1'b0;
        else if (lane_ld[0]) fresh0 <= 1'b1;
        else if (ring[0])    fresh0 <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sout      <= 1'b0;
            first_bit <= 1'b0;
        end else begin
            sout      <= pick;
            first_bit <= ring[2] & fresh0;
        end
    end

    AST_LANE_ORDER_01: assert property (@(posedge clk) disable iff (rst)
        lane_ld[0] |=> lane_ld[1]); // R4
    AST_LANE_ORDER_12: assert property (@(posedge clk) disable iff (rst)
        lane_ld[1] |=> lane_ld[2]); // R4
    AST_LANES_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        (lane_ld != 3'b000) |-> !load_clk); // R4
    AST_FIRST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        first_bit |=> !first_bit); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!sout && !first_bit)); // R9

endmodule

// File: tb/ser3_interleaver_tb.sv
module ser3_interleaver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int W     = 3 * N;
    localparam int HALFW = W / 2;
    localparam int LAT   = HALFW + 6;
    localparam int NFULL = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par_data = '0;
    logic         load_req = 1'b0;
    logic         half_rate = 1'b0;
    logic         load_clk, sout, first_bit;

    int checks = 0;
    int fails  = 0;
    int word_lim = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser3_interleaver #(.N(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .par_data  (par_data),
        .load_req  (load_req),
        .half_rate (half_rate),
        .load_clk  (load_clk),
        .sout      (sout),
        .first_bit (first_bit)
    );

    function automatic logic stim_req(int j);
        if (j >= word_lim)           return 1'b0;
        if (j < NFULL + 64)          return 1'b1;
        return j[0];
    endfunction

    function automatic logic stim_half(int j);
        return (j >= NFULL) && (j < NFULL + 64);
    endfunction

    function automatic logic [W-1:0] stim_data(int j);
        logic [HALFW-1:0] u;
        if (j < NFULL) return W'(j);
        if (j < NFULL + 64) begin
            u = HALFW'(j - NFULL);
            return {u, ~u};
        end
        return '1;
    endfunction

    function automatic logic [W-1:0] exp_word(int j);
        logic [W-1:0] d, e;
        d = stim_data(j);
        if (!stim_half(j)) return d;
        for (int i = 0; i < HALFW; i++) begin
            e[W-1-2*i] = d[W-1-i];
            e[W-2-2*i] = d[W-1-i];
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, cyc, act, expv);
        end
    endtask

    task automatic check_cycle(input int k);
        logic es, ef;
        string ts;
        int d, j, i;
        chk((k < W) ? "R3 load_clk" : "R1 load_clk", load_clk, (k % W) < HALFW);
        es = 1'b0; ef = 1'b0; ts = "R9 quiet before first word";
        if (k >= W + LAT) begin
            d = k - W - LAT; j = d / W; i = d % W;
            if (stim_req(j)) begin
                es = exp_word(j)[W-1-i];
                ef = (i == 0);
                if (stim_half(j))  ts = "R8 half-rate bit";
                else if (i == 0)   ts = "R5 latency top bit";
                else if (i < 3)    ts = "R4 lane interleave";
                else               ts = "R2 serial order";
            end else begin
                ts = "R7 idle-low";
            end
        end
        chk(ts, sout, es);
        chk("R6 first_bit", first_bit, ef);
    endtask

    task automatic run_epoch(input int lim, input int ncyc);
        word_lim = lim;
        for (int k = 0; k < ncyc; k++) begin
            if (k > 0) @(negedge clk);
            else rst = 1'b0;
            cyc = k;
            if (k % W == 0) begin
                par_data  = stim_data(k / W);
                load_req  = stim_req(k / W);
                half_rate = stim_half(k / W);
            end
            check_cycle(k);
        end
    endtask

    task automatic check_reset();
        repeat (4) @(negedge clk);
        chk("R9 reset sout", sout, 1'b0);
        chk("R9 reset first_bit", first_bit, 1'b0);
        chk("R9 reset load_clk", load_clk, 1'b1);
    endtask

    initial begin
        rst = 1'b1;
        load_req = 1'b1;
        par_data = '1;
        check_reset();
        run_epoch(NFULL + 72, (NFULL + 74) * W + LAT + W);
        rst = 1'b1;
        check_reset();
        run_epoch(20, 24 * W);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule